// File: doc/BRIEF.md
# Single-Bit Modify and Test-Branch Unit

This unit carries out the single-bit instructions of an 8-bit CPU that work on page zero, the lowest 256 bytes of memory. It is started with an opcode and the address that opcode was fetched from. It fetches its own operand bytes through a byte-wide memory port. It then either rewrites one bit of a page-zero byte, or tests one bit of such a byte and computes the next program counter.

A bit-modify instruction is two bytes: the opcode, then a page-zero address. The unit reads the addressed byte, forces the chosen bit to 1 or 0, and writes the byte back. A test-branch instruction is three bytes: the opcode, a page-zero address, and a signed displacement. The unit copies the tested bit into carry. When the condition holds, it adds the displacement to the address of the following instruction. Opcodes outside these two groups are rejected without any memory access.

The memory port has one cycle of read latency: `mem_rdata_i` carries the byte for the read issued in the previous cycle. The results `pc_next_o`, `c_o`, `c_we_o` and `err_o` are valid only while `done_o` is high.

Top module: `bitop_unit`

## Requirements
- R1: After reset the unit is idle. `done_o`, `err_o`, `c_we_o`, `mem_rd_o` and `mem_wr_o` are all low until a start is accepted.
- R2: Opcode bits 7:4 select the group: 0000 is test-branch, 0001 is bit-modify, and every other value is illegal. Bits 3:1 give the bit index. Bit 0 is the sense. For bit-modify, sense 0 sets the bit and sense 1 clears it. For test-branch, sense 0 branches if the bit is set and sense 1 branches if it is clear.
- R3: A bit-modify reads the operand at pc+1, then reads page-zero byte {0,operand}. It then writes that byte back to the same address with only the chosen bit changed. `done_o` rises in the write cycle, which is the third cycle after the start cycle, and `pc_next_o` is pc+2.
- R4: A bit-modify never asserts `c_we_o`.
- R5: A test-branch reads pc+1, then the page-zero byte, then pc+2. `done_o` rises in the fourth cycle after start, with `c_we_o` high and `c_o` equal to the tested bit, whether or not the branch is taken.
- R6: A taken branch gives `pc_next_o` = pc+3 plus the sign-extended displacement, modulo 2^AW. This gives a reach of -128 to +127 from the following instruction.
- R7: A branch that is not taken gives `pc_next_o` = pc+3.
- R8: An illegal opcode raises `done_o` and `err_o` together, for one cycle, in the first cycle after start. It makes no memory read and no memory write.
- R9: `done_o` is high for exactly one cycle per instruction. `start_i` is ignored while an instruction is in progress.
- R10: A test-branch never writes memory and leaves the tested byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (accepted when idle) |
| opcode_i | input | 8 | Opcode, sampled with start |
| pc_i | input | AW | Address of the opcode, sampled with start |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Read request; data returns next cycle |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data for the previous cycle's request |
| done_o | output | 1 | End-of-instruction strobe |
| err_o | output | 1 | Illegal opcode, valid with done |
| pc_next_o | output | AW | Next program counter, valid with done |
| c_we_o | output | 1 | Carry update enable |
| c_o | output | 1 | New carry value |

## Verification
The bench builds the unit with the default AW of 16, so the program counter covers the full 64 KiB space. Its memory model folds every address onto 512 bytes. Program counters are drawn so that the operand bytes never alias page zero. With the full 16-bit width, the bench can place a forward branch just below 0xFFFF and a backward branch just above 0x0100. This checks the modulo wrap of the target and the full displacement range of -128 to +127.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    K_BRANCH  = 2'd0,
    K_MODIFY  = 2'd1,
    K_ILLEGAL = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] bit_idx;
    logic       sense;
  } dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OPND, S_BYTE, S_WRITE, S_DISP, S_FIN, S_ERR
  } state_e;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.bit_idx = opcode_i[3:1];
    dec_o.sense   = opcode_i[0];
    unique case (opcode_i[7:4])
      4'h0:    dec_o.kind = K_BRANCH;
      4'h1:    dec_o.kind = K_MODIFY;
      default: dec_o.kind = K_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] byte_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          sense_i,
  output logic [DW-1:0] byte_o,
  output logic          tbit_o
);
  logic [DW-1:0] mask;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bit_idx_i == IW'(i));
  end

  // sense 0: set, sense 1: clear
  assign byte_o = sense_i ? (byte_i & ~mask) : (byte_i | mask);
  assign tbit_o = |(byte_i & mask);
endmodule

// File: rtl/bitop_pcgen.sv
module bitop_pcgen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc_i,
  input  logic [7:0]    disp_i,
  input  logic          taken_i,
  output logic [AW-1:0] pc_mod_o,
  output logic [AW-1:0] pc_br_o
);
  logic [AW-1:0] pc_seq;
  logic [AW-1:0] disp_ext;

  assign disp_ext = AW'($signed(disp_i));
  assign pc_seq   = pc_i + AW'(3);
  assign pc_mod_o = pc_i + AW'(2);
  assign pc_br_o  = taken_i ? (pc_seq + disp_ext) : pc_seq;
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] pc_next_o,
  output logic          c_we_o,
  output logic          c_o
);
  localparam int PW = 8;

  state_e        state_q, state_d;
  dec_t          dec, dec_q;
  logic [AW-1:0] pc_q;
  logic [PW-1:0] zaddr_q;
  logic          tbit_q;
  logic [7:0]    mod_byte;
  logic          tbit;
  logic [AW-1:0] pc_mod, pc_br;

  bitop_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  bitop_alu #(.DW(8)) u_alu (
    .byte_i   (mem_rdata_i),
    .bit_idx_i(dec_q.bit_idx),
    .sense_i  (dec_q.sense),
    .byte_o   (mod_byte),
    .tbit_o   (tbit)
  );

  bitop_pcgen #(.AW(AW)) u_pc (
    .pc_i    (pc_q),
    .disp_i  (mem_rdata_i),
    .taken_i (tbit_q ^ dec_q.sense),
    .pc_mod_o(pc_mod),
    .pc_br_o (pc_br)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dec_q   <= '0;
      pc_q    <= '0;
      zaddr_q <= '0;
      tbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        dec_q <= dec;
        pc_q  <= pc_i;
      end
      if (state_q == S_BYTE) zaddr_q <= mem_rdata_i;
      if (state_q == S_DISP) tbit_q  <= tbit;
    end
  end

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    pc_next_o   = pc_q;
    c_we_o      = 1'b0;
    c_o         = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = (dec.kind == K_ILLEGAL) ? S_ERR : S_OPND;
      S_OPND: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pc_q + AW'(1);
        state_d    = S_BYTE;
      end
      S_BYTE: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = AW'(mem_rdata_i);
        state_d    = (dec_q.kind == K_BRANCH) ? S_DISP : S_WRITE;
      end
      S_WRITE: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = AW'(zaddr_q);
        mem_wdata_o = mod_byte;
        done_o      = 1'b1;
        pc_next_o   = pc_mod;
        state_d     = S_IDLE;
      end
      S_DISP: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pc_q + AW'(2);
        state_d    = S_FIN;
      end
      S_FIN: begin
        done_o    = 1'b1;
        c_we_o    = 1'b1;
        c_o       = tbit_q;
        pc_next_o = pc_br;
        state_d   = S_IDLE;
      end
      S_ERR: begin
        done_o  = 1'b1;
        err_o   = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_err_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !mem_rd_o && !mem_wr_o));
  a_r4_modify_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> !c_we_o);
  a_r3_write_page_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o[AW-1:8] == '0 && done_o));
  a_r3_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o));
  a_r5_carry_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o |-> (done_o && !err_o));
  a_r10_branch_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o |-> !mem_wr_o);
  a_r1_exclusive_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opcode = '0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;
  logic          done, err, c_we, c_val;
  logic [AW-1:0] pc_next;

  logic [7:0] mem [0:511];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bitop_unit #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .pc_i(pc),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done),
    .err_o(err), .pc_next_o(pc_next), .c_we_o(c_we), .c_o(c_val)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
    if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_pc(input logic [7:0] op, input logic [AW-1:0] p,
                                           input logic [7:0] b, input logic [7:0] d);
    logic bitv;
    bitv = b[op[3:1]];
    if (op[7:4] == 4'h1) return p + AW'(2);
    if (bitv != op[0]) return p + AW'(3) + {{(AW-8){d[7]}}, d};
    return p + AW'(3);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic [7:0] b);
    logic [7:0] r;
    r = b;
    r[op[3:1]] = ~op[0];
    return r;
  endfunction

  task automatic run(input logic [7:0] op, input logic [AW-1:0] p, input logic [7:0] za,
                     input logic [7:0] b, input logic [7:0] d);
    int done_k, done_n, wr_n, rd_n;
    logic [AW-1:0] got_pc, wr_addr;
    logic [7:0] wr_data;
    logic got_err, got_cwe, got_c;
    logic [3:0] grp;
    done_k = 0; done_n = 0; wr_n = 0; rd_n = 0;
    got_pc = '0; wr_addr = '0; wr_data = '0; got_err = 0; got_cwe = 0; got_c = 0;
    grp = op[7:4];
    mem[(p + AW'(1)) & 9'h1ff] = za;
    mem[(p + AW'(2)) & 9'h1ff] = d;
    mem[{1'b0, za}] = b;
    opcode = op; pc = p; start = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      // R9: start held/ignored after acceptance
      start = (k == 1) ? 1'b0 : start;
      if (mem_rd) rd_n++;
      if (mem_wr) begin wr_n++; wr_addr = mem_addr; wr_data = mem_wdata; end
      if (done) begin
        done_n++; done_k = k; got_pc = pc_next; got_err = err; got_cwe = c_we; got_c = c_val;
      end
    end
    check("R9 one done", done_n, 1);
    if (grp > 4'h1) begin
      check("R8 done cycle", done_k, 1);
      check("R8 err", got_err, 1);
      check("R8 no read", rd_n, 0);
      check("R8 no write", wr_n, 0);
      check("R8 byte kept", mem[{1'b0, za}], b);
    end else if (grp == 4'h1) begin
      check("R3 done cycle", done_k, 3);
      check("R3 err", got_err, 0);
      check("R3 reads", rd_n, 2);
      check("R3 one write", wr_n, 1);
      check("R3 write addr", wr_addr, {8'h00, za});
      check("R3 write data", wr_data, exp_byte(op, b));
      check("R3 mem byte", mem[{1'b0, za}], exp_byte(op, b));
      check("R3 pc next", got_pc, exp_pc(op, p, b, d));
      check("R4 no carry", got_cwe, 0);
    end else begin
      check("R5 done cycle", done_k, 4);
      check("R5 reads", rd_n, 3);
      check("R5 carry we", got_cwe, 1);
      check("R5 carry value", got_c, b[op[3:1]]);
      check("R10 no write", wr_n, 0);
      check("R10 byte kept", mem[{1'b0, za}], b);
      if (b[op[3:1]] != op[0]) check("R6 taken pc", got_pc, exp_pc(op, p, b, d));
      else                     check("R7 seq pc", got_pc, exp_pc(op, p, b, d));
    end
  endtask

  function automatic logic [AW-1:0] rand_pc();
    logic [7:0] lo;
    lo = 8'($urandom_range(0, 253));
    return {7'($urandom), 1'b1, lo};
  endfunction

  initial begin
    bit wd_hit;
    process p_main;
    wd_hit = 0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    fork
      begin
        p_main = process::self();
        repeat (3) @(negedge clk);
        check("R1 done idle", done, 0);
        check("R1 err idle", err, 0);
        check("R1 rd idle", mem_rd, 0);
        check("R1 wr idle", mem_wr, 0);
        check("R1 cwe idle", c_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {done, mem_rd, mem_wr}, 0);
        // R2 directed: every bit index, both senses
        for (int bi = 0; bi < 8; bi++) begin
          run(8'(8'h10 | (bi << 1)), 16'h0120, 8'h40, 8'h00, 8'h00);
          run(8'(8'h11 | (bi << 1)), 16'h0130, 8'h41, 8'hff, 8'h00);
          run(8'(bi << 1), 16'h0140, 8'h42, 8'(1 << bi), 8'h05);
          run(8'(1 | (bi << 1)), 16'h0150, 8'h43, 8'(1 << bi), 8'h05);
        end
        // R6 wrap forward, max reach both ways
        run(8'h00, 16'hfff0, 8'h10, 8'h01, 8'h7f);
        run(8'h01, 16'h0100, 8'h11, 8'h00, 8'h80);
        run(8'h0e, 16'h1fa0, 8'hff, 8'h80, 8'h80);
        // R8 illegal groups
        run(8'h20, 16'h0160, 8'h50, 8'h3c, 8'h00);
        run(8'hff, 16'h0170, 8'h51, 8'h3c, 8'h00);
        for (int n = 0; n < 300; n++) begin
          logic [7:0] op;
          op = 8'($urandom);
          if (n % 8 != 0) op[7:5] = 3'b000;
          run(op, rand_pc(), 8'($urandom), 8'($urandom), 8'($urandom));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) begin
      p_main.kill();
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule